// File: doc/BRIEF.md
# Two-Level Block-Scaled Dot Product Unit

The unit takes two blocks of sixteen narrow numbers each and returns their dot product as an exact fixed-point integer with a single exponent. Each block has one 8-bit shared exponent for all sixteen elements. Each block also has one fine scale bit for every pair of neighbouring elements, and every element is a sign-magnitude mantissa. The element mantissas are multiplied one by one. The two products of a pair are added, and that pair sum is scaled by the fine bits of both operands. The eight pair terms are then reduced to one value. The two shared exponents are added to give the exponent of the result.

The mantissa width is chosen on every input by a format code: 7, 4 or 2 magnitude bits. All three widths run through the same multipliers and adder tree. A fine bit of 1 means the pair is worth half as much. The unit does not shift the pair right and lose bits. It keeps two guard bits: every pair term is shifted left by two minus the number of fine bits set. The output therefore has two fractional bits and always equals the exact sum.

The unit has two register stages. The first holds the products. The second holds the reduced sum. A new input can be accepted on every clock, and each result appears two cycles after its input.

Top module: `mxdp_dot`

## Requirements
- R1: While `rst_n` is low, and directly after it, `out_valid`, `out_sum` and `out_exp` are all zero.
- R2: `out_valid` is high exactly two clock edges after an edge at which `in_valid` was high. Consecutive inputs give consecutive results, one per cycle.
- R3: Element i sits in bits [8i+7:8i] of its block vector. Bit 8i+7 is the sign, 1 meaning negative. The low bits hold the magnitude. A negative zero gives a zero product.
- R4: `fmt_sel` sets the magnitude width of each element: code 0 gives 7 bits, code 1 gives 4 bits, code 2 gives 2 bits and code 3 gives 7 bits. The code is taken with the same vector it arrives with.
- R5: Magnitude bits above the selected width (bits 8i+6 down to 8i+w) have no effect on the result.
- R6: Bit p of `a_micro` and of `b_micro` covers elements 2p and 2p+1. With s being the number of those two bits that are set, the pair's sum of products enters the result multiplied by 2^(2-s). `out_sum` therefore carries two fractional bits.
- R7: `out_exp` is the 9-bit unsigned sum `a_exp + b_exp` of the vector that produced the result. For example, 255 + 255 gives 510.
- R8: `out_sum` is the exact two's-complement sum and never wraps. Full scale with 7-bit magnitudes and no fine shift is +1032256, or -1032256 when the two signs differ.
- R9: On a cycle with `out_valid` low, `out_sum` and `out_exp` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input blocks and format code are valid this cycle |
| fmt_sel | input | 2 | Mantissa width code (R4) |
| a_exp | input | 8 | Shared exponent of block A |
| a_micro | input | 8 | Per-pair fine scale bits of block A |
| a_elems | input | 128 | Sixteen 8-bit sign-magnitude elements of block A |
| b_exp | input | 8 | Shared exponent of block B |
| b_micro | input | 8 | Per-pair fine scale bits of block B |
| b_elems | input | 128 | Sixteen 8-bit sign-magnitude elements of block B |
| out_valid | output | 1 | Result valid |
| out_sum | output | 22 | Signed fixed-point dot product, two fractional bits |
| out_exp | output | 9 | Result exponent, a_exp + b_exp |

## Verification
In the same cycle, the product stage can take in a new vector while the tree stage reduces the previous one. The two vectors may differ in format code, fine bits and sign pattern. To provoke this, the stimulus sends long back-to-back runs in which the format code, the fine bits and the exponents are random on every cycle. Idle cycles are mixed in so that loading and holding also meet at the second stage. Every cycle, the outputs are compared with a bench model that keeps a two-deep history of the expected results. A value from the wrong stage, or a format code taken from the wrong vector, therefore shows up as a mismatch in sum or exponent.

// File: rtl/mxdp_pkg.sv
package mxdp_pkg;

    localparam int unsigned MX_N_ELEM = 16;
    localparam int unsigned MX_EXP_W  = 8;
    localparam int unsigned MX_MAX_M  = 7;
    localparam int unsigned MX_MID_M  = 4;
    localparam int unsigned MX_LOW_M  = 2;

    typedef enum logic [1:0] {
        FMT_WIDE  = 2'd0,
        FMT_MID   = 2'd1,
        FMT_NARROW = 2'd2,
        FMT_WIDE_ALT = 2'd3
    } mx_fmt_e;

endpackage

// File: rtl/mxdp_elem_mul.sv
module mxdp_elem_mul #(
    parameter int unsigned MAX_M = 7
) (
    input  logic [MAX_M:0]       a_elem,
    input  logic [MAX_M:0]       b_elem,
    input  logic [MAX_M-1:0]     mag_mask,
    output logic [2*MAX_M:0]     prod
);
    localparam int unsigned MAG_W = 2 * MAX_M;

    logic [MAX_M-1:0] mag_a;
    logic [MAX_M-1:0] mag_b;
    logic [MAG_W-1:0] mag_p;
    logic             neg;

    always_comb begin
        mag_a = a_elem[MAX_M-1:0] & mag_mask;
        mag_b = b_elem[MAX_M-1:0] & mag_mask;
        mag_p = MAG_W'(mag_a) * MAG_W'(mag_b);
        neg   = a_elem[MAX_M] ^ b_elem[MAX_M];
        prod  = neg ? (~{1'b0, mag_p} + 1'b1) : {1'b0, mag_p};
    end

endmodule

// File: rtl/mxdp_pair_tree.sv
module mxdp_pair_tree #(
    parameter int unsigned N_ELEM = 16,
    parameter int unsigned MAX_M  = 7
) (
    input  logic [N_ELEM*(2*MAX_M+1)-1:0] prod_flat,
    input  logic [N_ELEM-1:0]             shift_flat,
    output logic signed [2*MAX_M+7:0]     acc
);
    localparam int unsigned PROD_W = 2 * MAX_M + 1;
    localparam int unsigned ACC_W  = 2 * MAX_M + 8;
    localparam int unsigned PAIRS  = N_ELEM / 2;

    logic signed [ACC_W-1:0] terms [PAIRS];

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic signed [PROD_W-1:0] pa;
        logic signed [PROD_W-1:0] pb;
        logic signed [ACC_W-1:0]  psum;
        logic [1:0]               sh;

        assign pa   = $signed(prod_flat[(2*p)*PROD_W +: PROD_W]);
        assign pb   = $signed(prod_flat[(2*p+1)*PROD_W +: PROD_W]);
        assign psum = ACC_W'(pa) + ACC_W'(pb);
        assign sh   = shift_flat[2*p +: 2];

        always_comb begin
            case (sh)
                2'd0:    terms[p] = psum <<< 2;
                2'd1:    terms[p] = psum <<< 1;
                default: terms[p] = psum;
            endcase
        end
    end

    always_comb begin
        acc = '0;
        for (int p = 0; p < PAIRS; p++) begin
            acc = acc + terms[p];
        end
    end

endmodule

// File: rtl/mxdp_dot.sv
module mxdp_dot
    import mxdp_pkg::*;
#(
    parameter int unsigned N_ELEM = MX_N_ELEM,
    parameter int unsigned EXP_W  = MX_EXP_W,
    parameter int unsigned MAX_M  = MX_MAX_M,
    parameter int unsigned MID_M  = MX_MID_M,
    parameter int unsigned LOW_M  = MX_LOW_M
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [1:0]                    fmt_sel,
    input  logic [EXP_W-1:0]              a_exp,
    input  logic [N_ELEM/2-1:0]           a_micro,
    input  logic [N_ELEM*(MAX_M+1)-1:0]   a_elems,
    input  logic [EXP_W-1:0]              b_exp,
    input  logic [N_ELEM/2-1:0]           b_micro,
    input  logic [N_ELEM*(MAX_M+1)-1:0]   b_elems,
    output logic                          out_valid,
    output logic signed [2*MAX_M+7:0]     out_sum,
    output logic [EXP_W:0]                out_exp
);
    localparam int unsigned ELEM_W = MAX_M + 1;
    localparam int unsigned PAIRS  = N_ELEM / 2;
    localparam int unsigned PROD_W = 2 * MAX_M + 1;
    localparam int unsigned ACC_W  = 2 * MAX_M + 8;

    typedef struct packed {
        logic                        s1_v;
        logic [N_ELEM*PROD_W-1:0]    s1_prod;
        logic [2*PAIRS-1:0]          s1_shift;
        logic [EXP_W:0]              s1_exp;
        logic                        s2_v;
        logic signed [ACC_W-1:0]     s2_sum;
        logic [EXP_W:0]              s2_exp;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    logic [MAX_M-1:0]          mag_mask;
    logic [N_ELEM*PROD_W-1:0]  prod_flat;
    logic [2*PAIRS-1:0]        shift_flat;
    logic signed [ACC_W-1:0]   tree_acc;

    always_comb begin
        case (mx_fmt_e'(fmt_sel))
            FMT_MID:    mag_mask = {MAX_M{1'b1}} >> (MAX_M - MID_M);
            FMT_NARROW: mag_mask = {MAX_M{1'b1}} >> (MAX_M - LOW_M);
            default:    mag_mask = {MAX_M{1'b1}};
        endcase
    end

    for (genvar i = 0; i < N_ELEM; i++) begin : g_mul
        mxdp_elem_mul #(.MAX_M(MAX_M)) mul_i (
            .a_elem   (a_elems[i*ELEM_W +: ELEM_W]),
            .b_elem   (b_elems[i*ELEM_W +: ELEM_W]),
            .mag_mask (mag_mask),
            .prod     (prod_flat[i*PROD_W +: PROD_W])
        );
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_shift
        assign shift_flat[2*p +: 2] = {1'b0, a_micro[p]} + {1'b0, b_micro[p]};
    end

    mxdp_pair_tree #(.N_ELEM(N_ELEM), .MAX_M(MAX_M)) tree_i (
        .prod_flat  (st_q.s1_prod),
        .shift_flat (st_q.s1_shift),
        .acc        (tree_acc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.s1_v = in_valid;
        if (in_valid) begin
            st_d.s1_prod  = prod_flat;
            st_d.s1_shift = shift_flat;
            st_d.s1_exp   = {1'b0, a_exp} + {1'b0, b_exp};
        end
        st_d.s2_v = st_q.s1_v;
        if (st_q.s1_v) begin
            st_d.s2_sum = tree_acc;
            st_d.s2_exp = st_q.s1_exp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.s2_v;
    assign out_sum   = st_q.s2_sum;
    assign out_exp   = st_q.s2_exp;

endmodule

module mxdp_dot_chk #(
    parameter int unsigned N_ELEM = 16,
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned MAX_M  = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [EXP_W-1:0]          a_exp,
    input logic [EXP_W-1:0]          b_exp,
    input logic                      out_valid,
    input logic signed [2*MAX_M+7:0] out_sum,
    input logic [EXP_W:0]            out_exp
);
    localparam int signed FULL = int'(N_ELEM) * ((2**MAX_M - 1) ** 2) * 4;

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r7_exp_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid) |->
            (out_exp == ({1'b0, $past(a_exp, 2)} + {1'b0, $past(b_exp, 2)})));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && !out_valid) |-> ($stable(out_sum) && $stable(out_exp)));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_sum) <= FULL && int'(out_sum) >= -FULL));

endmodule

bind mxdp_dot mxdp_dot_chk #(.N_ELEM(N_ELEM), .EXP_W(EXP_W), .MAX_M(MAX_M)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_exp     (a_exp),
    .b_exp     (b_exp),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_exp   (out_exp)
);

// File: tb/mxdp_dot_tb_top.sv
module mxdp_dot_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   fmt_sel = '0;
    logic [7:0]   a_exp = '0, b_exp = '0;
    logic [7:0]   a_micro = '0, b_micro = '0;
    logic [127:0] a_elems = '0, b_elems = '0;
    logic         out_valid;
    logic signed [21:0] out_sum;
    logic [8:0]   out_exp;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    bit    hv [2];
    int    hs [2];
    int    he [2];
    string ht [2];
    int    last_sum = 0;
    int    last_exp = 0;

    always #10 clk = ~clk;

    mxdp_dot dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
        .a_exp(a_exp), .a_micro(a_micro), .a_elems(a_elems),
        .b_exp(b_exp), .b_micro(b_micro), .b_elems(b_elems),
        .out_valid(out_valid), .out_sum(out_sum), .out_exp(out_exp)
    );

    function automatic int ref_sum(input logic [1:0] f, input logic [7:0] am, input logic [7:0] bm,
                                   input logic [127:0] ae, input logic [127:0] be);
        int mw = (f == 2'd1) ? 4 : (f == 2'd2) ? 2 : 7;
        int total = 0;
        for (int p = 0; p < 8; p++) begin
            int ps = 0;
            int s = int'(am[p]) + int'(bm[p]);
            for (int k = 0; k < 2; k++) begin
                logic [7:0] ea = ae[8*(2*p+k) +: 8];
                logic [7:0] eb = be[8*(2*p+k) +: 8];
                int ma = int'(ea[6:0]) & ((1 << mw) - 1);
                int mb = int'(eb[6:0]) & ((1 << mw) - 1);
                int pr = ma * mb;
                ps += (ea[7] ^ eb[7]) ? -pr : pr;
            end
            total += ps * (1 << (2 - s));
        end
        return total;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] f, input logic [7:0] ax, input logic [7:0] bx,
                        input logic [7:0] am, input logic [7:0] bm,
                        input logic [127:0] ae, input logic [127:0] be, input string tag);
        @(negedge clk);
        check(out_valid == hv[1], "R2 valid", int'(out_valid), int'(hv[1]));
        if (hv[1]) begin
            last_sum = hs[1];
            last_exp = he[1];
            check(int'(out_sum) == hs[1], ht[1], int'(out_sum), hs[1]);
            check(int'(out_exp) == he[1], "R7 exponent", int'(out_exp), he[1]);
        end else begin
            check(int'(out_sum) == last_sum, "R9 hold sum", int'(out_sum), last_sum);
            check(int'(out_exp) == last_exp, "R9 hold exp", int'(out_exp), last_exp);
        end
        hv[1] = hv[0]; hs[1] = hs[0]; he[1] = he[0]; ht[1] = ht[0];
        hv[0] = v;
        hs[0] = ref_sum(f, am, bm, ae, be);
        he[0] = int'(ax) + int'(bx);
        ht[0] = tag;
        in_valid = v; fmt_sel = f; a_exp = ax; b_exp = bx;
        a_micro = am; b_micro = bm; a_elems = ae; b_elems = be;
    endtask

    function automatic logic [127:0] rnd_block();
        logic [127:0] r;
        for (int w = 0; w < 4; w++) r[32*w +: 32] = $urandom;
        return r;
    endfunction

    task automatic idle();
        step(1'b0, 2'd0, 8'd0, 8'd0, 8'd0, 8'd0, '0, '0, "R9 idle");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] all7f, allff, junk_hi, nz;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 2; i++) begin hv[i] = 0; hs[i] = 0; he[i] = 0; ht[i] = ""; end
        all7f = {16{8'h7F}};
        allff = {16{8'hFF}};
        junk_hi = {16{8'h7C}};
        nz = {16{8'h80}};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(int'(out_sum) == 0, "R1 sum", int'(out_sum), 0);
        check(int'(out_exp) == 0, "R1 exp", int'(out_exp), 0);
        rst_n = 1'b1;

        // R8 full scale, both signs, back to back
        step(1'b1, 2'd0, 8'd10, 8'd20, 8'h00, 8'h00, all7f, all7f, "R8 full positive");
        if (hs[0] != 1032256) check(1'b0, "R8 model", hs[0], 1032256);
        step(1'b1, 2'd0, 8'd1, 8'd2, 8'h00, 8'h00, allff, all7f, "R8 full negative");
        // R6 all fine bits set on both sides (s=2) and on one side (s=1)
        step(1'b1, 2'd0, 8'd3, 8'd4, 8'hFF, 8'hFF, all7f, all7f, "R6 shift two");
        step(1'b1, 2'd0, 8'd3, 8'd4, 8'hA5, 8'h00, all7f, all7f, "R6 shift one");
        step(1'b1, 2'd0, 8'd3, 8'd4, 8'h0F, 8'h3C, rnd_block(), rnd_block(), "R6 mixed pairs");
        // R7 exponent extremes
        step(1'b1, 2'd0, 8'd255, 8'd255, 8'h00, 8'h00, all7f, all7f, "R7 max exp");
        // R4 codes, R5 ignored upper bits
        step(1'b1, 2'd1, 8'd5, 8'd5, 8'h00, 8'h00, all7f, all7f, "R4 four bits");
        step(1'b1, 2'd2, 8'd5, 8'd5, 8'h00, 8'h00, junk_hi, junk_hi, "R5 narrow ignores high");
        step(1'b1, 2'd3, 8'd5, 8'd5, 8'h00, 8'h00, all7f, allff, "R4 code three");
        step(1'b1, 2'd1, 8'd5, 8'd5, 8'h11, 8'h22, {16{8'hF0}}, all7f, "R5 mid ignores high");
        // R3 negative zero
        step(1'b1, 2'd0, 8'd0, 8'd0, 8'h00, 8'h00, nz, allff, "R3 negative zero");
        idle(); idle(); idle();

        // R2 random streams with idles mixed in
        for (int n = 0; n < 400; n++) begin
            bit v = ($urandom % 4) != 0;
            step(v, 2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 rnd_block(), rnd_block(), "R2 R3 R4 R6 random");
        end
        idle(); idle(); idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule